// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that a processor can load and read over a simple bus. Each advance comes from one of two sources. The first is the instruction-cycle tick, which is a one-clock enable once per instruction cycle. The second is a qualified edge on an external input. An external edge is captured at instruction ticks through a two-stage synchronizer, and one control bit chooses the rising or the falling edge.

The selected source either drives the count register directly or passes through an 8-bit binary prescaler. A 3-bit ratio field sets the prescaler division. When the count wraps from its all-ones value to zero, a sticky interrupt flag is set. The flag stays set until an explicit clear input removes it.

A bus write loads the count register. The write also holds off all counting for the next two instruction ticks. If the prescaler is in use, the write clears it as well. Software can therefore pre-adjust the value it writes to allow for the hold-off.

Top module: `pcnt_timer`

## Requirements
- R1: While `rst` is high and after it falls, `count_q` is 0 and `irq_flag` is 0. The prescaler and the write hold-off are also cleared, so with the bypass set the first instruction tick after reset advances the count.
- R2: With `src_ext`=0 and `pre_bypass`=1, the count advances by exactly one on each clock where `cyc_en` is 1 and does not change on any other clock.
- R3: With `src_ext`=1 and `edge_fall`=0, a rise of `ext_clk` is sampled at an instruction tick. It advances the count by one at the next instruction tick, so the count is unchanged after the first tick and incremented after the second. A falling transition causes no advance. A level held for many ticks yields only one advance.
- R4: With `src_ext`=1 and `edge_fall`=1, a fall of `ext_clk` advances the count with the same two-tick timing as R3, and a rise causes no advance.
- R5: With `pre_bypass`=0, the count advances once per 2^(`pre_ratio`+1) source events, counted from the last prescaler clear. This covers 1:2 at ratio 0 up to 1:256 at ratio 7.
- R6: A clock with `wr_en`=1 loads `wr_data` into `count_q`. The instruction ticks on that clock and on the next two instruction ticks cause no advance, and no prescaler advance either. The third tick after the write advances normally.
- R7: When `pre_bypass`=0, a write also clears the prescaler, so any source events that it had accumulated before the write are discarded.
- R8: An advance from 0xFF gives `count_q`=0x00 and sets `irq_flag` on the same clock edge.
- R9: `irq_flag` stays 1 until a clock with `flag_clr`=1 clears it. If a clear and a wrap occur on the same clock, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle tick, one clock wide |
| ext_clk | input | 1 | External count input, asynchronous |
| src_ext | input | 1 | Source select: 0 instruction tick, 1 external edge |
| edge_fall | input | 1 | External edge select: 0 rising, 1 falling |
| pre_bypass | input | 1 | 1 bypasses the prescaler |
| pre_ratio | input | 3 | Prescale ratio select, divide by 2^(value+1) |
| wr_en | input | 1 | Bus write strobe for the count |
| wr_data | input | 8 | Value to load into the count |
| flag_clr | input | 1 | Clears the interrupt flag |
| count_q | output | 8 | Current count (bus read data) |
| irq_flag | output | 1 | Sticky wrap interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit count, an 8-bit prescaler with a 3-bit ratio field, and a two-tick write hold-off. With these values the full 1:256 tap can be reached in a few hundred instruction ticks. The bench drives `cyc_en` once every four clocks, which exercises the gaps between ticks. A table walks several ratios across their division boundaries and across the hold-off boundary. Directed tests then cover the wrap from 0xFF, the same-cycle clear and wrap, both edge polarities with their two-tick latency, prescaler clearing on a write, and reset in the middle of a run.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Mask of (sel+1) low ones; the prescaler fires when these bits are all set.
  function automatic logic [31:0] tap_mask(input logic [4:0] sel);
    return (32'd2 << sel) - 32'd1;
  endfunction
endpackage

// File: rtl/pcnt_edge_sync.sv
module pcnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_en,
  input  logic ext_in,
  input  logic sel_fall,
  output logic edge_evt
);
  logic [STAGES-1:0] sh;
  logic newer, older;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else if (cyc_en) sh <= {sh[STAGES-2:0], ext_in};
  end

  assign newer = sh[STAGES-2];
  assign older = sh[STAGES-1];
  assign edge_evt = cyc_en && (sel_fall ? (older && !newer) : (!older && newer));

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> (!edge_evt || !$stable(sel_fall))); // R3
endmodule

// File: rtl/pcnt_prescaler.sv
module pcnt_prescaler
  import pcnt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int PS_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick_in,
  input  logic [PS_W-1:0] ratio,
  output logic            tick_out
);
  localparam int SEL_W = 5;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic [31:0]      wide_mask;

  always_comb begin
    wide_mask = tap_mask(SEL_W'(ratio));
    mask      = wide_mask[PRE_W-1:0];
  end

  assign tick_out = tick_in && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pre_cnt <= '0;
    else if (tick_in) pre_cnt <= pre_cnt + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_cnt == '0)); // R7
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core #(
  parameter int CNT_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             adv_tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             irq_flag,
  output logic             inhibit
);
  localparam int INH_W = $clog2(INH_CYC + 1);
  logic [INH_W-1:0] inh;
  logic             wrap;

  assign inhibit = (inh != '0);
  assign wrap    = adv_tick && !wr_en && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) inh <= '0;
    else if (wr_en) inh <= INH_W'(INH_CYC);
    else if (cyc_en && inh != '0) inh <= inh - INH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (wr_en) count <= wr_data;
    else if (adv_tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_flag <= 1'b0;
    else irq_flag <= wrap || (irq_flag && !flag_clr);
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count == $past(wr_data))); // R6
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !wr_en) |=> (count == $past(count))); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (adv_tick && !wr_en && count == {CNT_W{1'b1}}) |=> (irq_flag && count == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag); // R9
endmodule

// File: rtl/pcnt_timer.sv
module pcnt_timer #(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 8,
  parameter int PS_W    = 3,
  parameter int SYNC_N  = 2,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             ext_clk,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             pre_bypass,
  input  logic [PS_W-1:0]  pre_ratio,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_flag
);
  logic ext_evt, src_tick, pre_tick, adv_tick, inhibit;

  pcnt_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_in(ext_clk),
    .sel_fall(edge_fall), .edge_evt(ext_evt)
  );

  // Hold-off and a pending write gate the source ahead of the prescaler.
  assign src_tick = (src_ext ? ext_evt : cyc_en) && !inhibit && !wr_en;

  pcnt_prescaler #(.PRE_W(PRE_W), .PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .clr(wr_en && !pre_bypass),
    .tick_in(src_tick && !pre_bypass), .ratio(pre_ratio), .tick_out(pre_tick)
  );

  assign adv_tick = pre_bypass ? src_tick : pre_tick;

  pcnt_core #(.CNT_W(CNT_W), .INH_CYC(INH_CYC)) u_core (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .adv_tick(adv_tick),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count(count_q), .irq_flag(irq_flag), .inhibit(inhibit)
  );

  AST_ADV_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!cyc_en && !wr_en) |=> (count_q == $past(count_q))); // R2
endmodule

// File: tb/tb_pcnt_timer.sv
module tb_pcnt_timer;
  logic clk = 0, rst = 1, cyc_en = 0, ext_clk = 0, src_ext = 0, edge_fall = 0;
  logic pre_bypass = 1, wr_en = 0, flag_clr = 0;
  logic [2:0] pre_ratio = 0;
  logic [7:0] wr_data = 0, count_q;
  logic irq_flag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pcnt_timer dut (.clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_clk(ext_clk),
    .src_ext(src_ext), .edge_fall(edge_fall), .pre_bypass(pre_bypass),
    .pre_ratio(pre_ratio), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_q(count_q), .irq_flag(irq_flag));

  // fields: [31] bypass, [30:28] ratio, [27:16] ticks after write, [7:0] expected
  localparam logic [31:0] VEC [0:8] = '{
    {1'b1, 3'd0, 12'd10,  8'd0, 8'd8},
    {1'b1, 3'd0, 12'd2,   8'd0, 8'd0},
    {1'b1, 3'd0, 12'd3,   8'd0, 8'd1},
    {1'b0, 3'd0, 12'd10,  8'd0, 8'd4},
    {1'b0, 3'd1, 12'd18,  8'd0, 8'd4},
    {1'b0, 3'd2, 12'd34,  8'd0, 8'd4},
    {1'b0, 3'd3, 12'd17,  8'd0, 8'd0},
    {1'b0, 3'd3, 12'd18,  8'd0, 8'd1},
    {1'b0, 3'd7, 12'd514, 8'd0, 8'd2}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic icyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cyc_en = 1;
      @(negedge clk) cyc_en = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic bus_wr(input logic [7:0] v);
    @(negedge clk) begin wr_en = 1; wr_data = v; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count_q, 8'h00);
    chk("R1 flag in reset", {7'd0, irq_flag}, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 count after reset", count_q, 8'h00);
    icyc(1);
    chk("R1 first tick counts", count_q, 8'h01);
    icyc(3);
    chk("R2 one per tick", count_q, 8'h04);

    // Table: timer mode, ratio and hold-off boundaries (R2 R5 R6)
    for (int k = 0; k < 9; k++) begin
      @(negedge clk) begin pre_bypass = VEC[k][31]; pre_ratio = VEC[k][30:28]; end
      bus_wr(8'h00);
      icyc(int'(VEC[k][27:16]));
      chk($sformatf("R5/R6 vector %0d", k), count_q, VEC[k][7:0]);
    end

    // R8 wrap and R9 sticky flag
    @(negedge clk) begin pre_bypass = 1; end
    bus_wr(8'hFE);
    chk("R6 load value", count_q, 8'hFE);
    icyc(3);
    chk("R8 reach FF", count_q, 8'hFF);
    chk("R8 no flag yet", {7'd0, irq_flag}, 8'h00);
    icyc(1);
    chk("R8 wrap to 00", count_q, 8'h00);
    chk("R8 flag set", {7'd0, irq_flag}, 8'h01);
    icyc(5);
    chk("R9 flag sticky", {7'd0, irq_flag}, 8'h01);
    clr_flag();
    chk("R9 flag cleared", {7'd0, irq_flag}, 8'h00);
    bus_wr(8'hFF);
    icyc(2);
    @(negedge clk) begin cyc_en = 1; flag_clr = 1; end
    @(negedge clk) begin cyc_en = 0; flag_clr = 0; end
    chk("R9 wrap beats clear", {7'd0, irq_flag}, 8'h01);
    chk("R8 wrap count", count_q, 8'h00);
    clr_flag();

    // R7 write clears prescaler
    @(negedge clk) begin pre_bypass = 0; pre_ratio = 3'd1; end
    bus_wr(8'h00);
    icyc(5);
    chk("R7 partial", count_q, 8'h00);
    bus_wr(8'h10);
    icyc(5);
    chk("R7 cleared no early advance", count_q, 8'h10);
    icyc(1);
    chk("R7 advance after 4", count_q, 8'h11);

    // R3 rising edge counter mode
    @(negedge clk) begin pre_bypass = 1; src_ext = 1; edge_fall = 0; ext_clk = 0; end
    bus_wr(8'h20);
    icyc(3);
    chk("R3 idle no count", count_q, 8'h20);
    @(negedge clk) ext_clk = 1;
    icyc(1);
    chk("R3 first tick no count", count_q, 8'h20);
    icyc(1);
    chk("R3 second tick counts", count_q, 8'h21);
    icyc(6);
    chk("R3 held level single count", count_q, 8'h21);
    @(negedge clk) ext_clk = 0;
    icyc(3);
    chk("R3 fall ignored", count_q, 8'h21);

    // R4 falling edge
    @(negedge clk) edge_fall = 1;
    @(negedge clk) ext_clk = 1;
    icyc(3);
    chk("R4 rise ignored", count_q, 8'h21);
    @(negedge clk) ext_clk = 0;
    icyc(1);
    chk("R4 first tick no count", count_q, 8'h21);
    icyc(1);
    chk("R4 second tick counts", count_q, 8'h22);

    // R1 reset mid-run
    @(negedge clk) begin src_ext = 0; rst = 1; end
    @(negedge clk);
    chk("R1 mid-run reset count", count_q, 8'h00);
    @(negedge clk) rst = 0;
    icyc(1);
    chk("R1 no hold-off after reset", count_q, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule